// File: doc/BRIEF.md
# Thread Context Pull Reporter

This block saves one hardware thread's interrupt context to memory and then invalidates it. A trigger names a thread and the base address of that thread's two-line report area. The block reads a fixed set of ring words from the thread's context register file and writes each one to the odd (second) line of the report area. That line sits 0x80 bytes above the base. Each word lands at 0x80 plus its own register offset in the context map.

The context map has four 16-byte rings: user at 0x00, OS at 0x10, pool at 0x20 and physical at 0x30. Each ring holds four 32-bit words at +0, +4, +8 and +12. The read port addresses a word by its index, which is the byte offset divided by four.

After the memory accepts the last write, the block pulses an invalidate request naming the thread. The external context file then clears the valid bit, bit 31, of OS word 2, pool word 2 and physical word 2. One cycle later the block pulses done.

The memory port is valid/ready. While `mem_valid` is high and `mem_ready` is low, the address, data and byte enables hold steady, and the block makes no progress. The trigger is also valid/ready: `trig_ready` is high only while the block is idle. A trigger carries no data, so the value of the byte stored to start the operation has no effect.

Top module: `thread_ctx_pull`

## Requirements
- R1: `trig_ready` is 1 exactly when `busy` is 0. A trigger held during a pull waits and is accepted in the first idle cycle. `busy` rises in the cycle after acceptance.
- R2: A pull issues exactly five memory writes, in this order, to base plus 0x90, 0x98, 0xA8, 0xB0 and 0xB8. These are OS word 0, OS word 2, pool word 2, physical word 0 and the first byte of physical word 2.
- R3: Each write is big-endian. `mem_data[31:24]` goes to the lowest byte address. Byte enable `mem_be[i]` covers `mem_data[8i+7:8i]`. The four full words use `mem_be`=4'b1111. The physical word 2 write uses 4'b1000 and carries that word's top byte in `mem_data[31:24]`.
- R4: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_data` and `mem_be` stay unchanged on the next cycle.
- R5: `ctx_inv_valid` is 1 for exactly one cycle, the cycle after the last write is accepted, with `ctx_inv_thread` naming the pulled thread. The file then clears bit 31 of words 6, 10 and 14 of that thread, so a later pull of the same thread reports those bits as 0.
- R6: `done` is 1 for exactly one cycle, the cycle after `ctx_inv_valid`. That is the last busy cycle.
- R7: While busy, `ctx_lock` is one-hot on the pulled thread. When idle, it is 0.
- R8: After reset the block is idle: `trig_ready`=1, and `busy`, `done`, `mem_valid`, `ctx_inv_valid` and `ctx_lock` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_valid | input | 1 | Pull request |
| trig_ready | output | 1 | Request accepted (idle) |
| trig_thread | input | TID_W | Thread to pull |
| trig_base | input | ADDR_W | Byte address of the report line pair |
| ctx_rd_thread | output | TID_W | Context file read thread |
| ctx_rd_word | output | 4 | Context file word index (byte offset / 4) |
| ctx_rd_data | input | 32 | Context file read data, same cycle |
| ctx_inv_valid | output | 1 | Clear the three ring valid bits |
| ctx_inv_thread | output | TID_W | Thread to invalidate |
| ctx_lock | output | NUM_THREADS | Per-thread hold on context writes |
| mem_valid | output | 1 | Write request |
| mem_ready | input | 1 | Write accepted |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_data | output | 32 | Big-endian word data |
| mem_be | output | 4 | Byte enables |
| busy | output | 1 | Pull in progress |
| done | output | 1 | Pull and invalidation complete |

## Verification
A wrong step counter or a wrong word-index table shows up on the first write that it affects. That write goes to the wrong address, or with the wrong data or byte enables, in the very cycle the memory accepts it. A sequencer that leaves its write phase too early or too late shifts `ctx_inv_valid` and `done` off their fixed offsets from the last accepted write. The reference model flags that in the same cycle. A wrong latched thread shows at once on `ctx_lock`. It also shows later: the next pull of that thread still reports its valid bits as set.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SEND,
    ST_CLEAR,
    ST_DONE
  } tcp_state_e;

  localparam int unsigned NSTEP     = 5;
  localparam int unsigned STEP_W    = $clog2(NSTEP);
  localparam int unsigned WIDX_W    = 4;
  localparam int unsigned ODD_LINE  = 32'h80;

  // Context word index copied at each step, ascending address order
  function automatic logic [WIDX_W-1:0] step_word(input logic [STEP_W-1:0] s);
    case (s)
      3'd0:    step_word = 4'd4;   // OS word 0
      3'd1:    step_word = 4'd6;   // OS word 2
      3'd2:    step_word = 4'd10;  // pool word 2
      3'd3:    step_word = 4'd12;  // physical word 0
      default: step_word = 4'd14;  // physical word 2, first byte only
    endcase
  endfunction

  function automatic logic [3:0] step_be(input logic [STEP_W-1:0] s);
    step_be = (s == STEP_W'(NSTEP - 1)) ? 4'b1000 : 4'b1111;
  endfunction

endpackage

// File: rtl/tcp_seq.sv
module tcp_seq
  import tcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic              mem_ready,
  output tcp_state_e        state_q,
  output logic [STEP_W-1:0] step_q
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(NSTEP - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (trig_valid) begin
          state_q <= ST_FETCH;
          step_q  <= '0;
        end
        ST_FETCH: state_q <= ST_SEND;
        ST_SEND: if (mem_ready) begin
          if (step_q == LAST) begin
            state_q <= ST_CLEAR;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_CLEAR: state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tcp_word_stage.sv
module tcp_word_stage
  import tcp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [STEP_W-1:0] step,
  input  logic [31:0]       rd_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic [31:0]       data_q,
  output logic [3:0]        be_q
);

  logic [ADDR_W-1:0] offs;
  assign offs = ADDR_W'(ODD_LINE) + ADDR_W'({step_word(step), 2'b00});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (load) begin
      addr_q <= base + offs;
      data_q <= rd_data;
      be_q   <= step_be(step);
    end
  end

endmodule

// File: rtl/tcp_lock_decode.sv
module tcp_lock_decode #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned TID_W       = 2
) (
  input  logic                   active,
  input  logic [TID_W-1:0]       thread,
  output logic [NUM_THREADS-1:0] lock
);

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_lock
    assign lock[i] = active && (thread == TID_W'(i));
  end

endmodule

// File: rtl/thread_ctx_pull.sv
module thread_ctx_pull
  import tcp_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig_valid,
  output logic                   trig_ready,
  input  logic [TID_W-1:0]       trig_thread,
  input  logic [ADDR_W-1:0]      trig_base,
  output logic [TID_W-1:0]       ctx_rd_thread,
  output logic [WIDX_W-1:0]      ctx_rd_word,
  input  logic [31:0]            ctx_rd_data,
  output logic                   ctx_inv_valid,
  output logic [TID_W-1:0]       ctx_inv_thread,
  output logic [NUM_THREADS-1:0] ctx_lock,
  output logic                   mem_valid,
  input  logic                   mem_ready,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [31:0]            mem_data,
  output logic [3:0]             mem_be,
  output logic                   busy,
  output logic                   done
);

  tcp_state_e        state;
  logic [STEP_W-1:0] step;
  logic [TID_W-1:0]  thr_q;
  logic [ADDR_W-1:0] base_q;
  logic              fire;

  assign fire = (state == ST_IDLE) && trig_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '0;
      base_q <= '0;
    end else if (fire) begin
      thr_q  <= trig_thread;
      base_q <= trig_base;
    end
  end

  tcp_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .mem_ready  (mem_ready),
    .state_q    (state),
    .step_q     (step)
  );

  tcp_word_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (state == ST_FETCH),
    .base    (base_q),
    .step    (step),
    .rd_data (ctx_rd_data),
    .addr_q  (mem_addr),
    .data_q  (mem_data),
    .be_q    (mem_be)
  );

  tcp_lock_decode #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_lock (
    .active (busy),
    .thread (thr_q),
    .lock   (ctx_lock)
  );

  assign trig_ready     = (state == ST_IDLE);
  assign busy           = (state != ST_IDLE);
  assign mem_valid      = (state == ST_SEND);
  assign ctx_inv_valid  = (state == ST_CLEAR);
  assign done           = (state == ST_DONE);
  assign ctx_inv_thread = thr_q;
  assign ctx_rd_thread  = thr_q;
  assign ctx_rd_word    = step_word(step);

endmodule

// File: rtl/tcp_checker.sv
module tcp_checker #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned ADDR_W      = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   trig_valid,
  input logic                   trig_ready,
  input logic                   busy,
  input logic                   done,
  input logic                   ctx_inv_valid,
  input logic [NUM_THREADS-1:0] ctx_lock,
  input logic                   mem_valid,
  input logic                   mem_ready,
  input logic [ADDR_W-1:0]      mem_addr,
  input logic [31:0]            mem_data,
  input logic [3:0]             mem_be
);

  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !trig_ready); // R1
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && trig_ready |=> busy); // R1
  AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be == 4'b1111 || mem_be == 4'b1000)); // R3
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)); // R4
  AST_INV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_inv_valid |=> !ctx_inv_valid); // R5
  AST_INV_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_inv_valid |=> done); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R6
  AST_LOCK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(ctx_lock) == 1); // R7
  AST_LOCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ctx_lock == '0); // R7

endmodule

bind thread_ctx_pull tcp_checker #(.NUM_THREADS(NUM_THREADS), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .trig_valid    (trig_valid),
  .trig_ready    (trig_ready),
  .busy          (busy),
  .done          (done),
  .ctx_inv_valid (ctx_inv_valid),
  .ctx_lock      (ctx_lock),
  .mem_valid     (mem_valid),
  .mem_ready     (mem_ready),
  .mem_addr      (mem_addr),
  .mem_data      (mem_data),
  .mem_be        (mem_be)
);

// File: tb/thread_ctx_pull_bench.sv
module thread_ctx_pull_bench;

  localparam int NT = 4;
  localparam int AW = 32;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_valid = 1'b0;
  logic          trig_ready;
  logic [TW-1:0] trig_thread = '0;
  logic [AW-1:0] trig_base = '0;
  logic [TW-1:0] ctx_rd_thread;
  logic [3:0]    ctx_rd_word;
  logic [31:0]   ctx_rd_data;
  logic          ctx_inv_valid;
  logic [TW-1:0] ctx_inv_thread;
  logic [NT-1:0] ctx_lock;
  logic          mem_valid;
  logic          mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_data;
  logic [3:0]    mem_be;
  logic          busy;
  logic          done;

  logic [31:0] rf [NT][16];
  assign ctx_rd_data = rf[ctx_rd_thread][ctx_rd_word];

  always #2 clk = ~clk;

  thread_ctx_pull #(.NUM_THREADS(NT), .ADDR_W(AW)) u_thread_ctx_pull (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_thread(trig_thread), .trig_base(trig_base),
    .ctx_rd_thread(ctx_rd_thread), .ctx_rd_word(ctx_rd_word), .ctx_rd_data(ctx_rd_data),
    .ctx_inv_valid(ctx_inv_valid), .ctx_inv_thread(ctx_inv_thread), .ctx_lock(ctx_lock),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be), .busy(busy), .done(done)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int          m_phase = 0;   // 0 idle, 1 writing, 2 invalidate, 3 done
  int          m_thr = 0;
  logic [31:0] qa[$];
  logic [31:0] qd[$];
  logic [3:0]  qb[$];

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] ea, ed;
      logic [3:0]  eb;
      int          nxt;
      cycles++;
      nxt = m_phase;
      chk(trig_ready == (m_phase == 0), "R1 trig_ready", 64'(trig_ready), 64'(m_phase == 0));
      chk(busy == (m_phase != 0), "R1 busy", 64'(busy), 64'(m_phase != 0));
      chk(ctx_lock == ((m_phase != 0) ? NT'(1 << m_thr) : '0), "R7 lock", 64'(ctx_lock),
          64'((m_phase != 0) ? (1 << m_thr) : 0));
      chk(ctx_inv_valid == (m_phase == 2), "R5 inv pulse", 64'(ctx_inv_valid), 64'(m_phase == 2));
      chk(done == (m_phase == 3), "R6 done pulse", 64'(done), 64'(m_phase == 3));
      if (m_phase != 1) chk(!mem_valid, "R2 no stray write", 64'(mem_valid), 64'd0);
      if (m_phase == 1 && mem_valid && mem_ready) begin
        if (qa.size() == 0) begin
          chk(1'b0, "R2 extra write", 64'(mem_addr), 64'd0);
        end else begin
          ea = qa.pop_front(); ed = qd.pop_front(); eb = qb.pop_front();
          chk(mem_addr == ea, "R2 address", 64'(mem_addr), 64'(ea));
          chk(mem_be == eb, "R3 byte enables", 64'(mem_be), 64'(eb));
          if (eb == 4'b1000)
            chk(mem_data[31:24] == ed[31:24], "R3 top byte", 64'(mem_data[31:24]), 64'(ed[31:24]));
          else
            chk(mem_data == ed, "R3 word data", 64'(mem_data), 64'(ed));
          if (qa.size() == 0) nxt = 2;
        end
      end
      if (m_phase == 2) begin
        chk(ctx_inv_thread == TW'(m_thr), "R5 inv thread", 64'(ctx_inv_thread), 64'(m_thr));
        rf[ctx_inv_thread][6][31]  = 1'b0;
        rf[ctx_inv_thread][10][31] = 1'b0;
        rf[ctx_inv_thread][14][31] = 1'b0;
        nxt = 3;
      end
      if (m_phase == 3) nxt = 0;
      if (m_phase == 0 && trig_valid) begin
        int wi[5];
        wi = '{4, 6, 10, 12, 14};
        m_thr = int'(trig_thread);
        foreach (wi[k]) begin
          qa.push_back(trig_base + 32'h80 + 32'(wi[k] * 4));
          qd.push_back(rf[m_thr][wi[k]]);
          qb.push_back(k == 4 ? 4'b1000 : 4'b1111);
        end
        nxt = 1;
      end
      m_phase = nxt;
      if (cycles > 100000) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  // back-pressure driver
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = bp_en ? lfsr[0] : 1'b1;
  end

  task automatic pull(input int thr, input logic [31:0] base, input bit keep);
    @(posedge clk); #1;
    trig_valid = 1'b1; trig_thread = TW'(thr); trig_base = base;
    forever begin
      @(negedge clk);
      if (trig_ready) break;
    end
    @(posedge clk); #1;
    if (!keep) trig_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || trig_valid);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int t = 0; t < NT; t++)
      for (int w = 0; w < 16; w++)
        rf[t][w] = {1'b1, 7'(t * 5 + 1), 8'(w * 17), 16'hC3A5 ^ 16'(t * 257 + w)};
    repeat (4) @(negedge clk);
    // R8 reset state
    chk(trig_ready && !busy && !done && !mem_valid && !ctx_inv_valid && ctx_lock == '0,
        "R8 reset state", {trig_ready, busy, done, mem_valid, ctx_inv_valid, 4'(ctx_lock)}, 64'h100);
    @(posedge clk); #1 rst_n = 1'b1;
    // R2/R3: plain pull, memory always ready
    pull(1, 32'h0001_0000, 1'b0);
    wait_idle();
    // R4: pull under back-pressure
    bp_en = 1'b1;
    pull(3, 32'h0002_0300, 1'b0);
    wait_idle();
    // R5: second pull of thread 1 must report cleared valid bits
    pull(1, 32'h0003_0100, 1'b0);
    wait_idle();
    // R1: trigger held during a pull waits for idle
    pull(0, 32'h0004_0000, 1'b1);
    pull(2, 32'h0005_0200, 1'b0);
    wait_idle();
    bp_en = 1'b0;
    // R5: all pulled threads have their three valid bits cleared
    for (int t = 0; t < NT; t++) begin
      chk(rf[t][6][31] == 1'b0 && rf[t][10][31] == 1'b0 && rf[t][14][31] == 1'b0,
          "R5 valid bits cleared", {rf[t][6][31], rf[t][10][31], rf[t][14][31]}, 64'd0);
      chk(rf[t][4][31] == 1'b1, "R5 other words untouched", 64'(rf[t][4][31]), 64'd1);
    end
    chk(qa.size() == 0, "R2 all writes seen", 64'(qa.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule